// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave side of a four-wire serial control link. A host lowers the select line, clocks in a 16-bit command word on the serial data input, and raises select again. The word either writes one of a bank of control registers or asks for a value to be read back. Readable values are the control registers, the peak levels supplied on input ports, and a status word. The serial clock is fully asynchronous to the system clock. Only the finished word crosses into the system clock domain, through a toggle handshake synchronized with two flops.

A read result is returned MSB first on the serial data output during the following frame. The output drive enable is active only while select is low, and the pad turns it into a high-impedance output. Reset (power-down) returns every register to its parameterized default. After reset is released, an initialization window that lasts a set number of frame-clock ticks keeps the port busy. During that window writes are refused and flagged in a sticky error bit, while reads are still answered.

Top module: `ctrl_serial_port`

## Requirements
- R1: Bits are sampled on each rising `sclk` while `sel_n` is low, and the first bit is word bit 15. A command executes after the rising edge of `sel_n` only if the frame held exactly 16 rising `sclk` edges. Frames with fewer or more edges have no effect.
- R2: Word layout: bits 15:12 are the address, bit 11 is the direction (1 = read, 0 = write), bit 10 is ignored, and bits 9:0 are the data.
- R3: A write to address i, where i < NREG, sets register i. The result appears on `regs_flat[i*DW +: DW]` within 8 `clk` cycles of `sel_n` rising. No other register changes.
- R4: Read map:
  - Addresses 0..NREG-1 return the registers.
  - Addresses NREG..NREG+NPEAK-1 return `peak_in[j*DW +: DW]`.
  - Address 15 returns status, with bit 0 = busy and bit 1 = error.
  - Every other address returns 0.
- R5: Read timing: in the frame after a read, `sdo` gives the value MSB first. Bit k is valid before the (k+1)-th rising `sclk`. After DW bits `sdo` is 0, and in the frame after a write `sdo` is 0.
- R6: A write to a peak address, to an unmapped address, or with a direction bit of 1 does not change any register.
- R7: `sdo_oe` is high exactly while `sel_n` is low, and `sdo` is 0 whenever `sdo_oe` is low.
- R8: While `rst_n` is low, every register holds its value from `REG_DEFAULTS`, `busy` is 1 and the error bit is 0.
- R9: After reset is released, `busy` stays high until INIT_FRAMES `frame_tick` pulses have been seen. It falls in the cycle after the last pulse and never rises again without a reset.
- R10: A write executed while `busy` is high changes no register and sets the sticky error bit. Reads are still answered while busy.
- R11: A write to address 15 made while not busy clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset / power-down, asynchronous |
| frame_tick | input | 1 | One-cycle pulse per frame-clock period, in the `clk` domain |
| sel_n | input | 1 | Frame select / latch, active low |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial command data in |
| sdo | output | 1 | Serial read data out |
| sdo_oe | output | 1 | Output drive enable for `sdo` (high-impedance when low) |
| peak_in | input | NPEAK*DW | Peak levels, entry j at bits j*DW +: DW |
| regs_flat | output | NREG*DW | Control registers, register i at bits i*DW +: DW |
| busy | output | 1 | Initialization window in progress |

## Verification
The bench builds the block with DW=10, NREG=8 and NPEAK=4. These values exercise both edges of the peak range (addresses 8 and 11) and the unmapped addresses 12 to 14. INIT_FRAMES is set to 3, so the whole initialization window can be run out, and its last tick checked, in a few cycles. The register defaults are a distinct pattern for each index, and each peak input has its own value. This means a write that lands in the wrong register, or a read served from the wrong register, shows up as a mismatch.

// File: rtl/ctrl_serial_port.sv
module ctrl_serial_port #(
  parameter int DW = 10,
  parameter int NREG = 8,
  parameter int NPEAK = 4,
  parameter int INIT_FRAMES = 20,
  parameter logic [NREG*DW-1:0] REG_DEFAULTS = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  input  logic                sel_n,
  input  logic                sclk,
  input  logic                sdi,
  output logic                sdo,
  output logic                sdo_oe,
  input  logic [NPEAK*DW-1:0] peak_in,
  output logic [NREG*DW-1:0]  regs_flat,
  output logic                busy
);
  localparam int IW = $clog2(INIT_FRAMES + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_FRAMES);
  localparam logic [3:0] STAT_ADDR = 4'hF;

  // serial clock side
  logic [4:0]  bit_cnt;
  logic [15:0] shreg;

  always_ff @(posedge sclk or posedge sel_n)
    if (sel_n) bit_cnt <= '0;
    else if (bit_cnt != 5'd31) bit_cnt <= bit_cnt + 5'd1;

  always_ff @(posedge sclk)
    if (!sel_n) shreg <= {shreg[14:0], sdi};

  // latch edge capture
  logic [15:0] cap_word;
  logic        cap_tog;

  always_ff @(posedge sel_n or negedge rst_n)
    if (!rst_n) begin
      cap_word <= '0;
      cap_tog  <= 1'b0;
    end else if (bit_cnt == 5'd16) begin
      cap_word <= shreg;
      cap_tog  <= ~cap_tog;
    end

  // system clock side
  logic [2:0] tog_sync;
  logic       exec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tog_sync <= '0;
    else tog_sync <= {tog_sync[1:0], cap_tog};

  assign exec = tog_sync[2] ^ tog_sync[1];

  logic [3:0]    cmd_addr;
  logic          cmd_rd;
  logic [DW-1:0] cmd_data;
  logic          unused_rsvd;

  assign cmd_addr    = cap_word[15:12];
  assign cmd_rd      = cap_word[11];
  assign unused_rsvd = cap_word[10];
  assign cmd_data    = cap_word[DW-1:0];

  logic [IW-1:0] init_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) init_cnt <= '0;
    else if (frame_tick && init_cnt != INIT_LAST) init_cnt <= init_cnt + 1'b1;

  assign busy = (init_cnt != INIT_LAST);

  logic wr_ok;
  assign wr_ok = exec && !cmd_rd && !busy;

  logic err;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err <= 1'b0;
    else if (exec && !cmd_rd) begin
      if (busy) err <= 1'b1;
      else if (cmd_addr == STAT_ADDR) err <= 1'b0;
    end

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= REG_DEFAULTS[i*DW +: DW];
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr_ok && cmd_addr == 4'(i)) regs[i] <= cmd_data;
    end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = regs[g];
  end

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (cmd_addr == 4'(i)) rd_val = regs[i];
    for (int j = 0; j < NPEAK; j++)
      if (cmd_addr == 4'(NREG + j)) rd_val = peak_in[j*DW +: DW];
    if (cmd_addr == STAT_ADDR) begin
      rd_val[1] = err;
      rd_val[0] = busy;
    end
  end

  logic [DW-1:0] out_val;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_val <= '0;
    else if (exec) out_val <= cmd_rd ? rd_val : '0;

  logic [DW-1:0] out_sh;
  assign out_sh = out_val << bit_cnt;
  assign sdo_oe = ~sel_n;
  assign sdo    = sdo_oe & out_sh[DW-1];
endmodule

module ctrl_serial_port_chk #(
  parameter int RW = 80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_tick,
  input logic          busy,
  input logic          err,
  input logic          exec,
  input logic          cmd_rd,
  input logic [RW-1:0] regs_flat
);
  assert_busy_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(busy));

  assert_busy_fall_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_tick));

  assert_busy_blocks_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(regs_flat));

  assert_err_from_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(busy && exec && !cmd_rd));

  assert_reg_change_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_flat) |-> $past(exec && !cmd_rd));
endmodule

bind ctrl_serial_port ctrl_serial_port_chk #(.RW(NREG*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .busy(busy), .err(err),
  .exec(exec), .cmd_rd(cmd_rd), .regs_flat(regs_flat)
);

// File: tb/sim_ctrl_serial_port.sv
module sim_ctrl_serial_port;
  localparam int DW = 10;
  localparam int NREG = 8;
  localparam int NPEAK = 4;
  localparam int INITF = 3;

  function automatic logic [NREG*DW-1:0] mk_def();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = DW'(10'h040 + i*5);
    return v;
  endfunction

  function automatic logic [NPEAK*DW-1:0] mk_peak();
    logic [NPEAK*DW-1:0] v;
    for (int j = 0; j < NPEAK; j++) v[j*DW +: DW] = DW'(10'h0A0 + j*19);
    return v;
  endfunction

  localparam logic [NREG*DW-1:0]  DEF  = mk_def();
  localparam logic [NPEAK*DW-1:0] PEAK = mk_peak();

  logic clk = 0, rst_n = 0, frame_tick = 0, sel_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_oe, busy;
  logic [NREG*DW-1:0] regs_flat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctrl_serial_port #(.DW(DW), .NREG(NREG), .NPEAK(NPEAK), .INIT_FRAMES(INITF),
                     .REG_DEFAULTS(DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .sel_n(sel_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .peak_in(PEAK), .regs_flat(regs_flat),
    .busy(busy));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [31:0] bits, input int n, output logic [DW-1:0] got);
    got = '0;
    sel_n = 0;
    #30;
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      #20;
      if (i < DW) got = {got[DW-2:0], sdo};
      sclk = 1;
      #20;
      sclk = 0;
    end
    #20;
    sel_n = 1;
    repeat (10) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [9:0] d);
    logic [DW-1:0] g;
    frame({16'h0, a, 2'b00, d}, 16, g);
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] v);
    logic [DW-1:0] g;
    frame({16'h0, a, 2'b10, 10'h000}, 16, g);
    frame(32'h0, 12, v);
  endtask

  task automatic tick();
    @(negedge clk) frame_tick = 1;
    @(negedge clk) frame_tick = 0;
  endtask

  typedef struct packed {
    logic       is_rd;
    logic [3:0] addr;
    logic [9:0] data;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd2,  10'h155}, '{1'b1, 4'd2,  10'h155},
    '{1'b0, 4'd7,  10'h3FF}, '{1'b1, 4'd7,  10'h3FF},
    '{1'b1, 4'd0,  10'h040}, '{1'b1, 4'd8,  10'h0A0},
    '{1'b1, 4'd9,  10'h0B3}, '{1'b1, 4'd11, 10'h0D9},
    '{1'b0, 4'd9,  10'h0AA}, '{1'b1, 4'd9,  10'h0B3},
    '{1'b1, 4'd12, 10'h000}, '{1'b1, 4'd13, 10'h000},
    '{1'b0, 4'd13, 10'h2AA}, '{1'b1, 4'd13, 10'h000},
    '{1'b1, 4'd15, 10'h000}, '{1'b0, 4'd0,  10'h001},
    '{1'b1, 4'd0,  10'h001}, '{1'b1, 4'd2,  10'h155}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [NREG*DW-1:0] snap;
    repeat (5) @(negedge clk);
    check("R8 busy in reset", 32'(busy), 1);
    check("R8 defaults in reset", regs_flat[31:0], DEF[31:0]);
    check("R8 defaults hi", 32'(regs_flat[79:32]), 32'(DEF[79:32]));
    check("R7 oe idle", {31'h0, sdo_oe}, 0);
    check("R7 sdo idle", {31'h0, sdo}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R10: write refused while busy, reads served
    wr(4'd3, 10'h222);
    check("R10 write blocked", 32'(regs_flat[3*DW +: DW]), 32'(DEF[3*DW +: DW]));
    rd(4'd15, v);
    check("R10 status busy+err", 32'(v), 3);
    rd(4'd5, v);
    check("R10 read while busy", 32'(v), 32'(DEF[5*DW +: DW]));

    // R9: init window length
    tick(); tick();
    check("R9 busy before last tick", 32'(busy), 1);
    tick();
    check("R9 busy after last tick", 32'(busy), 0);
    repeat (3) tick();
    check("R9 busy stays low", 32'(busy), 0);

    // R11: sticky error then clear
    rd(4'd15, v);
    check("R10 err sticky", 32'(v), 2);
    wr(4'd15, 10'h000);
    rd(4'd15, v);
    check("R11 err cleared", 32'(v), 0);

    // table: R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      if (VEC[k].is_rd) begin
        rd(VEC[k].addr, v);
        check($sformatf("R4 R5 read vec %0d", k), 32'(v), 32'(VEC[k].data));
      end else begin
        snap = regs_flat;
        wr(VEC[k].addr, VEC[k].data);
        for (int i = 0; i < NREG; i++)
          check($sformatf("R3 R6 write vec %0d reg %0d", k, i),
                32'(regs_flat[i*DW +: DW]),
                (VEC[k].addr == 4'(i)) ? 32'(VEC[k].data) : 32'(snap[i*DW +: DW]));
      end
    end

    // R2: reserved bit 10 ignored
    frame({16'h0, 4'd4, 2'b01, 10'h1C3}, 16, v);
    check("R2 reserved bit ignored", 32'(regs_flat[4*DW +: DW]), 32'h1C3);

    // R6: read-direction word with data does not write
    frame({16'h0, 4'd6, 2'b10, 10'h111}, 16, v);
    check("R6 read no write", 32'(regs_flat[6*DW +: DW]), 32'(DEF[6*DW +: DW]));

    // R5: sdo zero after a write
    wr(4'd1, 10'h0F0);
    frame(32'h0, 12, v);
    check("R5 sdo after write", 32'(v), 0);

    // R1: wrong lengths ignored
    frame({17'h0, 4'd1, 2'b00, 10'h3}, 15, v);
    check("R1 short frame ignored", 32'(regs_flat[1*DW +: DW]), 32'h0F0);
    frame({16'h0, 1'b1, 4'd1, 2'b00, 10'h3}, 17, v);
    check("R1 long frame ignored", 32'(regs_flat[1*DW +: DW]), 32'h0F0);

    // R7: drive enable follows select
    sel_n = 0;
    #10;
    check("R7 oe in frame", {31'h0, sdo_oe}, 1);
    sel_n = 1;
    #10;
    check("R7 oe after frame", {31'h0, sdo_oe}, 0);
    repeat (10) @(negedge clk);

    // R8: reset mid-run
    rst_n = 0;
    @(negedge clk);
    check("R8 reset restores", 32'(regs_flat[2*DW +: DW]), 32'(DEF[2*DW +: DW]));
    check("R8 busy again", 32'(busy), 1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule